// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block sequences clock-enable and power state for each rank behind a DRAM memory controller. It watches per-rank request activity and the package power state, and decides for each rank whether to run, to drop into power-down after an idle period, or to take the whole memory into self-refresh. It drives per-rank CKE, chip-select enable and clock enable, and sends precharge-all, refresh, self-refresh-entry and self-refresh-exit commands to a command arbiter through a valid/ready handshake.

Dynamic power-down comes in two flavours chosen by a configuration bit. In the open-page flavour CKE simply drops. In the closed-page flavour a precharge-all goes out first. Every refresh is bracketed: all ranks are woken, precharged and refreshed, then put back into power-down at once. Self-refresh entry depends on the package state and on whether graphics is integrated (it shares memory) or external. A request that reaches a sleeping rank is held off for a fixed exit time before its grant is given.

Top module: `dram_rank_pwr_ctl`

## Requirements
- R1: With open-page power-down selected (`pd_precharge_i`=0), a populated rank that sees no request for `idle_limit_i` cycles has its CKE driven low on the next cycle, so CKE falls `idle_limit_i`+1 clock edges after its request drops, and no command is issued for it.
- R2: With closed-page power-down selected (`pd_precharge_i`=1), idle ranks are first sent a precharge-all (op code 0) whose `cmd_rank_o` mask names them, and their CKE falls on the edge where that command is accepted, `idle_limit_i`+2 edges after the requests drop when `cmd_ready_i` is held high.
- R3: `pstate_i` encodes 0 = C0/C1/C1E, 1 = C3/C6/C7, 2 = S3, 3 = S4. In state 1 with external graphics (`gfx_int_i`=0), the memory enters self-refresh (self-refresh entry is op code 2; afterwards CKE and clock enable low on all ranks) when no rank has a request, whatever the graphics-idle and display flags are. In state 0, self-refresh is never entered.
- R4: In state 1 with integrated graphics (`gfx_int_i`=1), self-refresh is entered only while `gfx_idle_i`=1, `disp_pend_i`=0 and no rank has a request; otherwise the ranks stay under dynamic power-down.
- R5: In state 2, self-refresh is entered once every pending request has drained, and CKE stays low with no grant given for as long as state 2 lasts, even when new requests arrive.
- R6: A pulse on `ref_due_i` wakes every rank, then issues precharge-all (op 0) followed by refresh (op code 1) while every populated rank has CKE high; on the edge where the refresh is accepted, every populated rank without a pending request powers down again without waiting for its idle count.
- R7: A refresh request that arrives while a closed-page power-down entry is waiting for its precharge-all to be accepted is held; the power-down completes first and the refresh sequence follows.
- R8: A request to a rank in power-down raises only that rank's CKE; the grant appears `PDX_LAT`+1 clock edges after the request, and never in the cycle right after the rank was still powered down.
- R9: Leaving self-refresh issues a self-refresh-exit command (op code 3) and grants the first request `SRX_LAT`+2 clock edges after it arrives, with `cmd_ready_i` held high.
- R10: A rank whose `rank_present_i` bit is 0 has CKE, chip-select enable, clock enable and grant held low at all times.
- R11: In state 3, CKE, chip-select enable and clock enable of all ranks are low from the cycle after the state is seen; when the state leaves 3, ranks are restored after the self-refresh exit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pstate_i | input | 2 | Package power-state code |
| gfx_int_i | input | 1 | 1 = integrated graphics shares memory |
| gfx_idle_i | input | 1 | Graphics engine idle |
| disp_pend_i | input | 1 | Display requests pending |
| pd_precharge_i | input | 1 | 1 = closed-page power-down, 0 = open-page |
| idle_limit_i | input | IDLE_W | Idle cycles before power-down |
| rank_present_i | input | NUM_RANKS | Populated-rank mask |
| rank_req_i | input | NUM_RANKS | Pending request per rank |
| ref_due_i | input | 1 | Refresh-due pulse |
| cmd_ready_i | input | 1 | Arbiter accepts the command |
| cmd_valid_o | output | 1 | Command offered |
| cmd_op_o | output | 2 | Command op code |
| cmd_rank_o | output | NUM_RANKS | Ranks addressed by the command |
| rank_gnt_o | output | NUM_RANKS | Request may proceed to the arbiter |
| cke_o | output | NUM_RANKS | Per-rank CKE |
| cs_en_o | output | NUM_RANKS | Per-rank chip-select enable |
| clk_en_o | output | NUM_RANKS | Per-rank clock enable |

## Verification
The hardest situation to reach is a refresh request landing inside a closed-page power-down entry, since the precharge-all normally completes in a single cycle. The bench holds `cmd_ready_i` low so the entry stalls with its command pending, pulses `ref_due_i` into that window, then releases ready and checks that CKE falls before the refresh command appears. Exit latencies are measured by counting edges from the request to the grant, from both power-down and self-refresh.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_DEEP   = 2'd1,
    PS_SUSP   = 2'd2,
    PS_OFF    = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    OP_PREA = 2'd0,
    OP_REF  = 2'd1,
    OP_SRE  = 2'd2,
    OP_SRX  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    RK_UP   = 2'd0,
    RK_PD   = 2'd1,
    RK_EXIT = 2'd2
  } rank_st_e;

  typedef enum logic [3:0] {
    G_RUN, G_PD_PRE, G_REF_UP, G_REF_PRE, G_REF_CMD,
    G_SR_UP, G_SR_PRE, G_SR_ENT, G_SR, G_SR_X, G_SR_W, G_OFF
  } seq_st_e;
endpackage

// File: rtl/sr_policy.sv
module sr_policy
  import dram_pwr_pkg::*;
(
  input  logic [1:0] pstate_i,
  input  logic       gfx_int_i,
  input  logic       gfx_idle_i,
  input  logic       disp_pend_i,
  input  logic       any_req_i,
  output logic       sr_enter_o,
  output logic       sr_hold_o
);
  logic gfx_ok, deep, susp;

  assign deep  = pstate_i == PS_DEEP;
  assign susp  = pstate_i == PS_SUSP;
  // external graphics never vetoes self-refresh
  assign gfx_ok = !gfx_int_i || (gfx_idle_i && !disp_pend_i);

  assign sr_enter_o = !any_req_i && (susp || (deep && gfx_ok));
  assign sr_hold_o  = susp || (deep && gfx_ok && !any_req_i);
endmodule

// File: rtl/rank_pwr_unit.sv
module rank_pwr_unit
  import dram_pwr_pkg::*;
#(
  parameter int IDLE_W  = 8,
  parameter int PDX_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              present_i,
  input  logic              req_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic              pd_go_i,
  input  logic              wake_i,
  input  logic              hold_i,
  input  logic              run_i,
  output logic              idle_hit_o,
  output logic              up_o,
  output logic              cke_o,
  output logic              gnt_o
);
  localparam int XW = (PDX_LAT > 1) ? $clog2(PDX_LAT) : 1;

  rank_st_e          st_q;
  logic [IDLE_W-1:0] cnt_q;
  logic [XW-1:0]     xcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RK_UP;
      cnt_q  <= '0;
      xcnt_q <= '0;
    end else if (hold_i) begin
      st_q   <= RK_UP;
      cnt_q  <= '0;
      xcnt_q <= '0;
    end else begin
      case (st_q)
        RK_UP:   if (pd_go_i) st_q <= RK_PD;
        RK_PD:   if (req_i || wake_i) begin
                   st_q   <= RK_EXIT;
                   xcnt_q <= XW'(PDX_LAT - 1);
                 end
        RK_EXIT: if (xcnt_q == '0) st_q <= RK_UP;
                 else xcnt_q <= xcnt_q - 1'b1;
        default: st_q <= RK_UP;
      endcase
      // idle count restarts on any request or while not awake
      if (st_q != RK_UP || req_i) cnt_q <= '0;
      else if (cnt_q < idle_limit_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign up_o       = st_q == RK_UP;
  assign idle_hit_o = present_i && up_o && !req_i && (cnt_q >= idle_limit_i);
  assign cke_o      = present_i && !hold_i && (st_q != RK_PD);
  assign gnt_o      = present_i && run_i && req_i && up_o && !hold_i;

  // R8
  pd_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RK_PD) |=> !gnt_o);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import dram_pwr_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int SRX_LAT   = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           pstate_i,
  input  logic                 sr_enter_i,
  input  logic                 sr_hold_i,
  input  logic                 ref_due_i,
  input  logic                 precharge_i,
  input  logic [NUM_RANKS-1:0] present_i,
  input  logic [NUM_RANKS-1:0] req_i,
  input  logic [NUM_RANKS-1:0] idle_hit_i,
  input  logic [NUM_RANKS-1:0] up_i,
  input  logic                 cmd_ready_i,
  output logic                 cmd_valid_o,
  output logic [1:0]           cmd_op_o,
  output logic [NUM_RANKS-1:0] cmd_rank_o,
  output logic [NUM_RANKS-1:0] pd_go_o,
  output logic                 run_o,
  output logic                 wake_o,
  output logic                 hold_o,
  output logic                 sr_o,
  output logic                 off_o
);
  localparam int XW = (SRX_LAT > 1) ? $clog2(SRX_LAT) : 1;

  seq_st_e              st_q, st_d;
  logic                 ref_pend_q;
  logic [NUM_RANKS-1:0] pd_mask_q;
  logic [XW-1:0]        xcnt_q;
  logic                 xload, all_up;

  assign all_up = &(up_i | ~present_i);

  always_comb begin
    st_d        = st_q;
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_PREA;
    cmd_rank_o  = present_i;
    pd_go_o     = '0;
    xload       = 1'b0;
    case (st_q)
      G_RUN: begin
        if (ref_pend_q)                     st_d = G_REF_UP;
        else if (sr_enter_i)                st_d = G_SR_UP;
        else if (precharge_i && |idle_hit_i) st_d = G_PD_PRE;
        else if (!precharge_i)              pd_go_o = idle_hit_i;
      end
      G_PD_PRE: begin
        cmd_valid_o = 1'b1;
        cmd_rank_o  = pd_mask_q;
        if (cmd_ready_i) begin
          pd_go_o = pd_mask_q & idle_hit_i;
          st_d    = G_RUN;
        end
      end
      G_REF_UP:  if (all_up) st_d = G_REF_PRE;
      G_REF_PRE: begin
        cmd_valid_o = 1'b1;
        if (cmd_ready_i) st_d = G_REF_CMD;
      end
      G_REF_CMD: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_REF;
        if (cmd_ready_i) begin
          pd_go_o = present_i & ~req_i;
          st_d    = G_RUN;
        end
      end
      G_SR_UP: begin
        if (!sr_enter_i) st_d = G_RUN;
        else if (all_up) st_d = G_SR_PRE;
      end
      G_SR_PRE: begin
        cmd_valid_o = 1'b1;
        if (cmd_ready_i) st_d = G_SR_ENT;
      end
      G_SR_ENT: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_SRE;
        if (cmd_ready_i) st_d = G_SR;
      end
      G_SR: if (!sr_hold_i) st_d = G_SR_X;
      G_SR_X: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_SRX;
        if (cmd_ready_i) begin
          st_d  = G_SR_W;
          xload = 1'b1;
        end
      end
      G_SR_W: if (xcnt_q == '0) st_d = G_RUN;
      G_OFF: if (pstate_i != PS_OFF) begin
        st_d  = G_SR_W;
        xload = 1'b1;
      end
      default: st_d = G_RUN;
    endcase
    if (pstate_i == PS_OFF) st_d = G_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= G_RUN;
      ref_pend_q <= 1'b0;
      pd_mask_q  <= '0;
      xcnt_q     <= '0;
    end else begin
      st_q <= st_d;
      // refresh is moot while memory self-refreshes or is off
      if (st_q == G_SR || st_q == G_OFF)            ref_pend_q <= 1'b0;
      else if (st_q == G_RUN && st_d == G_REF_UP)   ref_pend_q <= 1'b0;
      else if (ref_due_i)                           ref_pend_q <= 1'b1;
      if (st_q == G_RUN && st_d == G_PD_PRE) pd_mask_q <= idle_hit_i;
      if (xload) xcnt_q <= XW'(SRX_LAT - 1);
      else if (st_q == G_SR_W && xcnt_q != '0) xcnt_q <= xcnt_q - 1'b1;
    end
  end

  assign run_o  = st_q == G_RUN;
  assign wake_o = (st_q == G_REF_UP) || (st_q == G_SR_UP);
  assign hold_o = (st_q == G_SR) || (st_q == G_OFF);
  assign sr_o   = st_q == G_SR;
  assign off_o  = st_q == G_OFF;

  // R7
  pd_pre_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == G_PD_PRE && !cmd_ready_i && pstate_i != PS_OFF) |=> (cmd_valid_o && cmd_op_o == OP_PREA));
endmodule

// File: rtl/dram_rank_pwr_ctl.sv
module dram_rank_pwr_ctl
  import dram_pwr_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int IDLE_W    = 8,
  parameter int PDX_LAT   = 4,
  parameter int SRX_LAT   = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           pstate_i,
  input  logic                 gfx_int_i,
  input  logic                 gfx_idle_i,
  input  logic                 disp_pend_i,
  input  logic                 pd_precharge_i,
  input  logic [IDLE_W-1:0]    idle_limit_i,
  input  logic [NUM_RANKS-1:0] rank_present_i,
  input  logic [NUM_RANKS-1:0] rank_req_i,
  input  logic                 ref_due_i,
  input  logic                 cmd_ready_i,
  output logic                 cmd_valid_o,
  output logic [1:0]           cmd_op_o,
  output logic [NUM_RANKS-1:0] cmd_rank_o,
  output logic [NUM_RANKS-1:0] rank_gnt_o,
  output logic [NUM_RANKS-1:0] cke_o,
  output logic [NUM_RANKS-1:0] cs_en_o,
  output logic [NUM_RANKS-1:0] clk_en_o
);
  logic                 sr_enter, sr_hold;
  logic                 run, wake, hold, in_sr, off;
  logic [NUM_RANKS-1:0] idle_hit, up, pd_go, act_req;

  assign act_req = rank_req_i & rank_present_i;

  sr_policy u_policy (
    .pstate_i    (pstate_i),
    .gfx_int_i   (gfx_int_i),
    .gfx_idle_i  (gfx_idle_i),
    .disp_pend_i (disp_pend_i),
    .any_req_i   (|act_req),
    .sr_enter_o  (sr_enter),
    .sr_hold_o   (sr_hold)
  );

  pwr_seq_fsm #(.NUM_RANKS(NUM_RANKS), .SRX_LAT(SRX_LAT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pstate_i    (pstate_i),
    .sr_enter_i  (sr_enter),
    .sr_hold_i   (sr_hold),
    .ref_due_i   (ref_due_i),
    .precharge_i (pd_precharge_i),
    .present_i   (rank_present_i),
    .req_i       (act_req),
    .idle_hit_i  (idle_hit),
    .up_i        (up),
    .cmd_ready_i (cmd_ready_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_rank_o  (cmd_rank_o),
    .pd_go_o     (pd_go),
    .run_o       (run),
    .wake_o      (wake),
    .hold_o      (hold),
    .sr_o        (in_sr),
    .off_o       (off)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rank_pwr_unit #(.IDLE_W(IDLE_W), .PDX_LAT(PDX_LAT)) u_rank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .present_i    (rank_present_i[r]),
      .req_i        (rank_req_i[r]),
      .idle_limit_i (idle_limit_i),
      .pd_go_i      (pd_go[r]),
      .wake_i       (wake),
      .hold_i       (hold),
      .run_i        (run),
      .idle_hit_o   (idle_hit[r]),
      .up_o         (up[r]),
      .cke_o        (cke_o[r]),
      .gnt_o        (rank_gnt_o[r])
    );
  end

  assign cs_en_o  = rank_present_i & {NUM_RANKS{!off}};
  assign clk_en_o = rank_present_i & {NUM_RANKS{!(off || in_sr)}};

  // R10
  absent_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cke_o | cs_en_o | clk_en_o | rank_gnt_o) & ~rank_present_i) == '0);
  // R11
  s4_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == PS_OFF) |=> ((cke_o | cs_en_o | clk_en_o) == '0));
  // R5
  s3_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sr && pstate_i == PS_SUSP) |=> (cke_o == '0 && rank_gnt_o == '0));
  // R6
  ref_cke_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_REF) |-> ((cke_o & rank_present_i) == rank_present_i));
endmodule

// File: tb/dram_rank_pwr_ctl_bench.sv
module dram_rank_pwr_ctl_bench;
  localparam int NR = 2;
  localparam int PDX = 4;
  localparam int SRX = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pst = 2'd0;
  logic       gint = 1'b0, gidle = 1'b1, disp = 1'b0, prech = 1'b0;
  logic [7:0] limit = 8'd255;
  logic [NR-1:0] present = 2'b11, req = 2'b00;
  logic       ref_due = 1'b0, ready = 1'b1;
  logic       cvalid;
  logic [1:0] cop;
  logic [NR-1:0] crank, gnt, cke, cs_en, clk_en;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dram_rank_pwr_ctl #(.NUM_RANKS(NR), .IDLE_W(8), .PDX_LAT(PDX), .SRX_LAT(SRX)) u_dram_rank_pwr_ctl (
    .clk_i(clk), .rst_ni(rst_n), .pstate_i(pst), .gfx_int_i(gint), .gfx_idle_i(gidle),
    .disp_pend_i(disp), .pd_precharge_i(prech), .idle_limit_i(limit),
    .rank_present_i(present), .rank_req_i(req), .ref_due_i(ref_due), .cmd_ready_i(ready),
    .cmd_valid_o(cvalid), .cmd_op_o(cop), .cmd_rank_o(crank), .rank_gnt_o(gnt),
    .cke_o(cke), .cs_en_o(cs_en), .clk_en_o(clk_en));

  // fields: pstate[7:6] gfx_int[5] gfx_idle[4] disp[3] req[2:1] expect_sr[0]
  localparam logic [7:0] SR_TAB [0:8] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    bit seen_a, seen_b;
    logic [NR-1:0] snap;
    int pd_k, ref_k;

    wait_n(3);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // reset state: all populated ranks awake, nothing pending (R1)
    chk(cke == 2'b11, "R1", cke, 3);
    chk(cs_en == 2'b11, "R10", cs_en, 3);
    chk(clk_en == 2'b11, "R10", clk_en, 3);
    chk(!cvalid, "R1", cvalid, 0);
    chk(gnt == 2'b00, "R8", gnt, 0);

    // self-refresh eligibility table (R3 R4 R5)
    for (int i = 0; i < 9; i++) begin
      logic [7:0] v;
      string tag;
      bit sr;
      v = SR_TAB[i];
      tag = (v[7:6] == 2'd2) ? "R5" : (v[5] ? "R4" : "R3");
      @(negedge clk);
      pst = v[7:6]; gint = v[5]; gidle = v[4]; disp = v[3]; req = v[2:1];
      wait_n(20);
      sr = (clk_en == 2'b00) && (cke == 2'b00);
      chk(sr == v[0], tag, sr, v[0]);
      pst = 2'd0; gint = 1'b0; gidle = 1'b1; disp = 1'b0; req = 2'b00;
      wait_n(30);
    end

    // R1: open-page idle power-down
    req = 2'b11;
    wait_n(10);
    limit = 8'd5; prech = 1'b0;
    @(negedge clk); req = 2'b00;
    n = 0; seen_a = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1; n++;
      if (cvalid) seen_a = 1;
      if (cke == 2'b00) break;
    end
    chk(n == 6, "R1", n, 6);
    chk(!seen_a, "R1", seen_a, 0);

    // R2: closed-page idle power-down with precharge-all
    @(negedge clk); req = 2'b11;
    wait_n(10);
    prech = 1'b1;
    @(negedge clk); req = 2'b00;
    n = 0; seen_a = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1; n++;
      if (cvalid && cop == 2'd0 && crank == 2'b11) seen_a = 1;
      if (cke == 2'b00) break;
    end
    chk(n == 7, "R2", n, 7);
    chk(seen_a, "R2", seen_a, 1);

    // R8: exit from power-down for one rank
    @(negedge clk); prech = 1'b0; req = 2'b01;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1; n++;
      if (gnt[0]) break;
    end
    chk(n == PDX + 1, "R8", n, PDX + 1);
    chk(cke == 2'b01, "R8", cke, 1);
    @(negedge clk); req = 2'b00;
    wait_n(15);

    // R6: refresh bracket
    chk(cke == 2'b00, "R6", cke, 0);
    @(negedge clk); ref_due = 1'b1;
    @(posedge clk); #1; ref_due = 1'b0;
    seen_a = 0; seen_b = 0; snap = '0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      if (cvalid && cop == 2'd0) seen_a = 1;
      if (cvalid && cop == 2'd1) begin seen_b = 1; snap = cke; break; end
    end
    chk(seen_a && seen_b, "R6", {seen_a, seen_b}, 3);
    chk(snap == 2'b11, "R6", snap, 3);
    @(posedge clk); #1;
    chk(cke == 2'b00, "R6", cke, 0);

    // R7: refresh arrives during a stalled closed-page entry
    @(negedge clk); req = 2'b11;
    wait_n(10);
    prech = 1'b1; ready = 1'b0; req = 2'b00;
    wait_n(12);
    chk(cvalid && cop == 2'd0 && cke == 2'b11, "R7", {cvalid, cop, cke}, 19);
    ref_due = 1'b1;
    @(negedge clk); ref_due = 1'b0;
    @(negedge clk); ready = 1'b1;
    pd_k = -1; ref_k = -1;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      if (cke == 2'b00 && pd_k < 0) pd_k = k;
      if (cvalid && cop == 2'd1) begin ref_k = k; break; end
    end
    chk(pd_k >= 0 && ref_k > pd_k, "R7", pd_k, 0);
    @(negedge clk); prech = 1'b0;
    wait_n(5);

    // R10: unpopulated rank stays dark even when requested
    present = 2'b01; req = 2'b10;
    wait_n(5);
    chk(cke[1] == 1'b0, "R10", cke[1], 0);
    chk(cs_en[1] == 1'b0, "R10", cs_en[1], 0);
    chk(clk_en[1] == 1'b0, "R10", clk_en[1], 0);
    chk(gnt[1] == 1'b0, "R10", gnt[1], 0);
    present = 2'b11; req = 2'b00;
    wait_n(10);

    // R5: S3 holds self-refresh through new requests
    pst = 2'd2;
    wait_n(30);
    chk(clk_en == 2'b00 && cke == 2'b00, "R5", {clk_en, cke}, 0);
    req = 2'b01;
    wait_n(20);
    chk(cke == 2'b00 && gnt == 2'b00, "R5", {cke, gnt}, 0);
    req = 2'b00;
    wait_n(2);

    // R3 then R9: move to deep idle with external graphics, then wake
    pst = 2'd1; gint = 1'b0;
    wait_n(5);
    chk(clk_en == 2'b00, "R3", clk_en, 0);
    @(negedge clk); req = 2'b01;
    n = 0; seen_a = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1; n++;
      if (cvalid && cop == 2'd3) seen_a = 1;
      if (gnt[0]) break;
    end
    chk(n == SRX + 2, "R9", n, SRX + 2);
    chk(seen_a, "R9", seen_a, 1);
    @(negedge clk); req = 2'b00; pst = 2'd0; limit = 8'd255;
    wait_n(10);

    // R11: S4 shuts everything, leaving it restores
    pst = 2'd3;
    @(posedge clk); #1;
    chk((cke | cs_en | clk_en) == 2'b00, "R11", {cke, cs_en, clk_en}, 0);
    chk(!cvalid, "R11", cvalid, 0);
    @(negedge clk); pst = 2'd0;
    wait_n(30);
    chk(cke == 2'b11 && cs_en == 2'b11 && clk_en == 2'b11, "R11", {cke, cs_en, clk_en}, 63);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule